// File: doc/BRIEF.md
# Early-Release Sync Word Pump

After a configuration image has been streamed into a target device, the device may still need extra clock edges with data before it signals that early release has happened. This block supplies them. On a start strobe it reads the current clock-to-data ratio field through a register port and remembers it. It then forces the field to the one-to-one code and sends all-ones filler words over a valid/ready word port until the early-release status input goes high.

The early-release flag is sampled before every word, so no word is sent once the flag is seen. Successive words are spaced by a fixed number of prescaled time ticks. An elapsed-time counter, also driven by the tick, ends the run with a timeout indication if the budget is exceeded before the flag rises. On either ending the remembered ratio is written back, a done pulse is given, and the number of filler words accepted is held on a count output until the next start.

Top module: `relwait_pump`

## Requirements
- R1: The cycle after a start strobe is taken in the idle state, the block issues a ratio write of the one-to-one code (value 0) after capturing the ratio read value; a start strobe while a run is active is ignored.
- R2: While filler words are being offered, the ratio field written by the block stays at the one-to-one code 0.
- R3: Every offered word is 32'hFFFF_FFFF, and an offered word stays offered until it is accepted.
- R4: The early-release flag is sampled before each word; if it is high no further word is offered, so a flag already high at start gives zero words.
- R5: After a word is accepted no word is offered for GAP_TICKS tick pulses, with exactly one further sampling cycle; with the tick every cycle the output idles GAP_TICKS+1 cycles between words, and time without tick pulses does not advance the gap.
- R6: If, at a sampling point with the flag low, more than TIMEOUT_TICKS tick pulses have elapsed since start, the run ends with timeout_o high; elapsed time counts only tick pulses.
- R7: When a run ends, by flag or by timeout, the ratio value captured at start is written back in the same cycle as a one-cycle done_o pulse.
- R8: count_o equals the number of filler words accepted in the latest run, is cleared by a start, and holds after the run ends.
- R9: After reset no word is offered, done_o, timeout_o and ratio_we_o are low and count_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| tick_i | input | 1 | Prescaled time-unit pulse for gap and timeout |
| rel_flag_i | input | 1 | Early-release status from the target |
| word_valid_o | output | 1 | Filler word offered |
| word_data_o | output | DATA_W | Filler word value (all ones) |
| word_ready_i | input | 1 | Data path accepts the word |
| ratio_rd_i | input | RATIO_W | Current clock-to-data ratio field |
| ratio_we_o | output | 1 | Ratio field write strobe |
| ratio_wdata_o | output | RATIO_W | Ratio field write value |
| done_o | output | 1 | One-cycle pulse when a run ends |
| timeout_o | output | 1 | Latest run ended on timeout |
| count_o | output | CNT_W | Filler words accepted in latest run |

## Verification
On every cycle the assertions check that an offered word is held until accepted, that nothing is offered while the gap timer runs or after a high flag has been sampled, that the count moves only on an accepted word, that done is a single pulse carrying a ratio write, that the forced one-to-one write follows each taken start, and that a timeout only follows an exceeded elapsed budget with the flag low. The exact number of words before early release or timeout, the ratio restored to its original value, the idle spacing between words, the freeze of both timers when ticks stop, and the rejection of a second start can only be shown by the bench's scenarios, which sweep the flag point and the ready latency against counts worked out arithmetically.

// File: rtl/relwait_pkg.sv
// Shared types for the early-release sync word pump.
package relwait_pkg;

    // Pump control states: idle, sample flag, offer word, wait gap.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SEND  = 2'd2,
        ST_GAP   = 2'd3
    } pump_state_e;

endpackage

// File: rtl/relwait_gap_timer.sv
// Gap timer: after load_i, counts GAP_TICKS pulses of tick_i and signals
// expiry on the last one. Assumes GAP_TICKS >= 1 and load_i is a pulse.
module relwait_gap_timer #(
    parameter int GAP_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic running_o,
    output logic expire_o
);
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [GW-1:0] LAST = GW'(GAP_TICKS - 1);

    logic [GW-1:0] cnt_q;
    logic          run_q;

    // Count tick pulses while running; stop on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q && tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign running_o = run_q;
    assign expire_o  = run_q && tick_i && (cnt_q == LAST);

    AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= LAST)); // R5

    AST_GAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !tick_i && !load_i) |=> (run_q && $stable(cnt_q))); // R5
endmodule

// File: rtl/relwait_elapsed_timer.sv
// Elapsed-time counter: cleared by clr_i, counts tick_i pulses while en_i,
// saturates one past LIMIT. exceeded_o is high once more than LIMIT
// pulses were seen. Assumes clr_i and en_i are not both needed at once.
module relwait_elapsed_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic tick_i,
    output logic exceeded_o
);
    localparam int EW = $clog2(LIMIT + 2);
    localparam logic [EW-1:0] CAP = EW'(LIMIT + 1);
    localparam logic [EW-1:0] LIM = EW'(LIMIT);

    logic [EW-1:0] cnt_q;

    // Saturating tick counter for the run's time budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && tick_i && (cnt_q != CAP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign exceeded_o = (cnt_q > LIM);

    AST_EXCEED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (exceeded_o && !clr_i) |=> exceeded_o); // R6

    AST_NO_TICK_NO_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/relwait_ratio_keeper.sv
// Ratio keeper: on save_i captures the ratio read value and writes the
// forced code; on restore_i writes the captured value back. Writes are
// one-cycle registered strobes. Assumes save_i and restore_i never coincide.
module relwait_ratio_keeper #(
    parameter int              RATIO_W = 2,
    parameter logic [RATIO_W-1:0] FORCE_CODE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               save_i,
    input  logic               restore_i,
    input  logic [RATIO_W-1:0] rd_i,
    output logic               we_o,
    output logic [RATIO_W-1:0] wdata_o
);
    logic [RATIO_W-1:0] saved_q;

    // Hold the ratio seen at start for the restore write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
        end else if (save_i) begin
            saved_q <= rd_i;
        end
    end

    // Issue the force or restore write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o    <= 1'b0;
            wdata_o <= '0;
        end else if (save_i) begin
            we_o    <= 1'b1;
            wdata_o <= FORCE_CODE;
        end else if (restore_i) begin
            we_o    <= 1'b1;
            wdata_o <= saved_q;
        end else begin
            we_o    <= 1'b0;
        end
    end

    AST_FORCE_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |=> (we_o && (wdata_o == FORCE_CODE))); // R1

    AST_WRITE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && !save_i && !restore_i) |=> !we_o); // R7
endmodule

// File: rtl/relwait_pump.sv
// Early-release sync word pump top. On start it saves the ratio field,
// forces one-to-one, then offers all-ones words with a tick-timed gap
// until the early-release flag is sampled high or the elapsed budget is
// exceeded; it then restores the ratio and pulses done. Assumes tick_i
// is a single-cycle pulse per time unit and GAP_TICKS >= 1.
module relwait_pump
    import relwait_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int RATIO_W       = 2,
    parameter int RATIO_ONE     = 0,
    parameter int GAP_TICKS     = 1000,
    parameter int TIMEOUT_TICKS = 1000000,
    parameter int CNT_W         = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               tick_i,
    input  logic               rel_flag_i,
    output logic               word_valid_o,
    output logic [DATA_W-1:0]  word_data_o,
    input  logic               word_ready_i,
    input  logic [RATIO_W-1:0] ratio_rd_i,
    output logic               ratio_we_o,
    output logic [RATIO_W-1:0] ratio_wdata_o,
    output logic               done_o,
    output logic               timeout_o,
    output logic [CNT_W-1:0]   count_o
);
    localparam logic [DATA_W-1:0]  FILL_WORD = '1;
    localparam logic [RATIO_W-1:0] ONE_CODE  = RATIO_W'(RATIO_ONE);
    localparam logic [CNT_W-1:0]   CNT_MAX   = '1;

    pump_state_e state_q;
    logic        start_take;
    logic        finish;
    logic        accept;
    logic        exceeded;
    logic        gap_running;
    logic        gap_expire;
    logic        done_q;
    logic        tmo_q;
    logic [CNT_W-1:0] count_q;

    assign start_take = start_i && (state_q == ST_IDLE);
    assign finish     = (state_q == ST_CHECK) && (rel_flag_i || exceeded);
    assign accept     = (state_q == ST_SEND) && word_ready_i;

    // Run control: sample flag, offer word, wait gap, end the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_CHECK;
                        count_q <= '0;
                        tmo_q   <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    if (rel_flag_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (exceeded) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        tmo_q   <= 1'b1;
                    end else begin
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (word_ready_i) begin
                        state_q <= ST_GAP;
                        if (count_q != CNT_MAX) begin
                            count_q <= count_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expire) begin
                        state_q <= ST_CHECK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    relwait_gap_timer #(
        .GAP_TICKS (GAP_TICKS)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .tick_i    (tick_i),
        .running_o (gap_running),
        .expire_o  (gap_expire)
    );

    relwait_elapsed_timer #(
        .LIMIT (TIMEOUT_TICKS)
    ) u_elapsed (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_take),
        .en_i       (state_q != ST_IDLE),
        .tick_i     (tick_i),
        .exceeded_o (exceeded)
    );

    relwait_ratio_keeper #(
        .RATIO_W    (RATIO_W),
        .FORCE_CODE (ONE_CODE)
    ) u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (start_take),
        .restore_i (finish),
        .rd_i      (ratio_rd_i),
        .we_o      (ratio_we_o),
        .wdata_o   (ratio_wdata_o)
    );

    assign word_valid_o = (state_q == ST_SEND);
    assign word_data_o  = FILL_WORD;
    assign done_o       = done_q;
    assign timeout_o    = tmo_q;
    assign count_o      = count_q;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !word_ready_i) |=> word_valid_o); // R3

    AST_FLAG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHECK) && rel_flag_i) |=> !word_valid_o); // R4

    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gap_running |-> !word_valid_o); // R5

    AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> ($past(exceeded) && !$past(rel_flag_i))); // R6

    AST_DONE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ratio_we_o); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_COUNT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o != $past(count_o)) && !$past(start_take))
            |-> $past(word_valid_o && word_ready_i)); // R8
endmodule

// File: tb/relwait_pump_test.sv
`timescale 1ns/1ps
module relwait_pump_test;
    localparam int GAP   = 3;
    localparam int TMO   = 20;
    localparam int RW    = 2;
    localparam int CW    = 8;
    localparam int MAXCYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tick = 1'b1;
    logic rel_flag = 1'b0;
    logic word_ready = 1'b0;
    logic word_valid;
    logic [31:0] word_data;
    logic [RW-1:0] ratio_reg = '0;
    logic ratio_we;
    logic [RW-1:0] ratio_wdata;
    logic done;
    logic timeout;
    logic [CW-1:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int accepted = 0;
    int flag_after = 0;
    bit flag_en = 1'b0;
    int rdy_delay = 0;
    int wait_cnt = 0;
    int low_run = 0;
    int last_gap = 0;

    always #2.5 clk = ~clk;

    relwait_pump #(
        .DATA_W(32), .RATIO_W(RW), .RATIO_ONE(0),
        .GAP_TICKS(GAP), .TIMEOUT_TICKS(TMO), .CNT_W(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .rel_flag_i(rel_flag), .word_valid_o(word_valid),
        .word_data_o(word_data), .word_ready_i(word_ready),
        .ratio_rd_i(ratio_reg), .ratio_we_o(ratio_we),
        .ratio_wdata_o(ratio_wdata), .done_o(done),
        .timeout_o(timeout), .count_o(count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Responder: ratio register model, ready with latency, flag source.
    always @(negedge clk) begin
        if (ratio_we) ratio_reg = ratio_wdata;
        if (word_valid) begin
            check(word_data == 32'hFFFF_FFFF, "R3 fill word", int'(word_data[15:0]), 16'hFFFF);
            check(ratio_reg == '0, "R2 ratio forced", int'(ratio_reg), 0);
            if (low_run > 0) last_gap = low_run;
            low_run = 0;
            if (wait_cnt >= rdy_delay) begin
                word_ready = 1'b1;
                accepted++;
            end else begin
                word_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            word_ready = 1'b0;
            wait_cnt = 0;
            low_run++;
        end
        rel_flag = flag_en && (accepted >= flag_after);
    end

    task automatic begin_run(input int k, input int d, input logic [RW-1:0] orig);
        @(negedge clk);
        accepted = 0;
        flag_after = k;
        flag_en = 1'b1;
        rdy_delay = d;
        ratio_reg = orig;
        last_gap = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        low_run = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(word_valid == 1'b0, "R9 valid", int'(word_valid), 0);
        check(done == 1'b0, "R9 done", int'(done), 0);
        check(timeout == 1'b0, "R9 timeout", int'(timeout), 0);
        check(ratio_we == 1'b0, "R9 ratio write", int'(ratio_we), 0);
        check(count == '0, "R9 count", int'(count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep flag point and ready latency against arithmetic results.
        for (int d = 0; d < 3; d++) begin
            for (int k = 0; k < 7; k++) begin
                int per;
                int ntmo;
                int expc;
                bit expt;
                logic [RW-1:0] orig;
                per  = 2 + d + GAP;
                ntmo = TMO / per + 1;
                expt = (k > ntmo);
                expc = expt ? ntmo : k;
                orig = RW'(k + d + 1);
                begin_run(k, d, orig);
                wait_done(seen);
                check(seen, "R7 done seen", int'(seen), 1);
                check(int'(count) == expc, "R8 count", int'(count), expc);
                check(timeout == expt, "R6 timeout", int'(timeout), int'(expt));
                if (k == 0) check(count == '0, "R4 zero words", int'(count), 0);
                @(negedge clk);
                check(ratio_reg == orig, "R7 ratio restored", int'(ratio_reg), int'(orig));
                check(accepted == expc, "R4 words on port", accepted, expc);
                check(done == 1'b0, "R7 done pulse", int'(done), 0);
                if (expc >= 2)
                    check(last_gap == GAP + 1, "R5 gap", last_gap, GAP + 1);
                repeat (2) @(negedge clk);
                check(int'(count) == expc, "R8 count held", int'(count), expc);
            end
        end

        // R1: second start during a run is ignored; original ratio kept.
        begin_run(3, 0, 2'd2);
        while (accepted < 1) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(int'(count) == 3, "R1 restart ignored count", int'(count), 3);
        @(negedge clk);
        check(ratio_reg == 2'd2, "R1 restart ignored ratio", int'(ratio_reg), 2);

        // R5/R6: ticks stopped freeze gap and elapsed time.
        begin_run(100, 0, 2'd3);
        while (accepted < 1) @(negedge clk);
        tick = 1'b0;
        begin
            bit moved;
            moved = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (word_valid || done) moved = 1'b1;
            end
            check(!moved, "R5 gap frozen without tick", int'(moved), 0);
        end
        flag_after = 1;
        tick = 1'b1;
        wait_done(seen);
        check(int'(count) == 1, "R6 no timeout while frozen", int'(count), 1);
        check(timeout == 1'b0, "R6 timeout low", int'(timeout), 0);
        @(negedge clk);
        check(ratio_reg == 2'd3, "R7 ratio after freeze", int'(ratio_reg), 3);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", MAXCYC, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule